// File: doc/BRIEF.md
# Banked Parallel Voxel Neighbourhood Fetch

This block holds a sliding window of image slices in on-chip banks and, for each request, delivers eight horizontally adjacent voxels together with all six face neighbours of each one. The eight results feed eight parallel compute lanes. A voxel at column `c` lives in bank `c mod 8`, so a single access to all eight banks returns one aligned group of eight columns. A slice lives in slot `slice mod SLOTS` of the window. A request names a row, a column group and a slice. The block reads the centre row, the rows above and below, and the same row in the neighbouring slices in a first RAM cycle. In a second RAM cycle it reads the two columns just outside the group: bank 7 of the group to the left and bank 0 of the group to the right.

Loading goes through a plain write port. Each write stores one aligned group of eight voxels into the slot chosen by its slice number. Reads go through a valid/ready request stream and a valid/ready result stream. The request side takes a new request at most every second cycle. The result side may stall for any length of time. Nothing is lost during a stall, because the block stops taking requests while two results are outstanding. `req_ready` also depends combinationally on `out_ready`, so a result popped in a cycle frees a place in that same cycle. `SLOTS` must be at least 3 so that the previous and next slices of a slice fall in different slots. `IMG_W` must be a multiple of 8.

Top module: `voxel_nbr_fetch`

## Requirements
- R1: A voxel written through the write port at column `c = grp*8 + i` (lane `i` taken from `wr_data[i*DW +: DW]`) of row `r` and slice `s` is stored in bank `c mod 8` of slot `s mod SLOTS` at bank address `r*(IMG_W/8) + c/8`. It is returned as the centre value of lane `i` when that row, group and slice are requested.
- R2: The result bundle places field `f` of lane `l` at `out_data[(l*7+f)*DW +: DW]`. The field codes are 0 centre, 1 left, 2 right, 3 up, 4 down, 5 previous slice, 6 next slice.
- R3: The left neighbour of lane `l>0` is centre `l-1`, and the right neighbour of lane `l<7` is centre `l+1`. Lane 0's left neighbour is column `grp*8-1` and lane 7's right neighbour is column `grp*8+8`, both taken from the adjacent groups.
- R4: The up and down fields carry the voxel at the same column in row `r-1` and row `r+1` of the same slice.
- R5: The previous and next fields carry the voxel at the same row and column held in slot `(s-1) mod SLOTS` and slot `(s+1) mod SLOTS`, including when the slot index wraps.
- R6: At the image's column edges, lane 0's left field (group 0) and lane 7's right field (last group) carry that lane's centre value.
- R7: At the row edges (row 0 up, row `IMG_H-1` down) and slice edges (slice 0 previous, slice `IMG_D-1` next), the missing neighbour is replaced by the centre value.
- R8: In the cycle after a request is accepted, `req_ready` is low, so requests are taken at most once every two cycles.
- R9: Results leave in request order. With the result queue empty and `out_ready` high, `out_valid` first rises three clock edges after the accepting edge.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. With two results outstanding and none leaving, `req_ready` is low.
- R11: After reset, `out_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store one eight-voxel group this cycle |
| wr_row | input | RW | Row of the stored group |
| wr_grp | input | GW | Column group of the stored group |
| wr_slice | input | SW | Slice number; selects slot `wr_slice mod SLOTS` |
| wr_data | input | 8*DW | Eight voxels, lane `i` at bits `i*DW` |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Fetch request taken when high with `req_valid` |
| req_row | input | RW | Requested row |
| req_grp | input | GW | Requested column group |
| req_slice | input | SW | Requested slice number |
| out_valid | output | 1 | Result bundle present |
| out_ready | input | 1 | Consumer takes the bundle |
| out_data | output | 56*DW | Eight lanes of seven fields |

## Verification
The bench builds the block with a 24-column, 5-row image, six slices and a four-slot window. Three column groups put a left-edge group, an interior group and a right-edge group all within reach. The bank depth of 15 is not a power of two. Because there are more slices than slots, slices 4 and 5 share slots with slices 0 and 1, so slot wrap for the neighbouring slices is exercised against slice-number edge handling. A blocked consumer fills both outstanding result places, and a random consumer mixes stalls into a burst of back-to-back requests.

// File: rtl/vf_pkg.sv
`timescale 1ns/1ps
package vf_pkg;
  localparam int LANES = 8;   // banks per slot, one per column residue
  localparam int NFLD  = 7;   // values per lane in the result bundle
  localparam int NCOPY = 3;   // copies of each bank for the three centre-slot rows

  typedef enum logic [2:0] {
    F_CTR   = 3'd0,
    F_LEFT  = 3'd1,
    F_RIGHT = 3'd2,
    F_UP    = 3'd3,
    F_DOWN  = 3'd4,
    F_PREV  = 3'd5,
    F_NEXT  = 3'd6
  } fld_e;
endpackage

// File: rtl/vf_bank_ram.sv
`timescale 1ns/1ps
module vf_bank_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vf_addr_gen.sv
`timescale 1ns/1ps
module vf_addr_gen import vf_pkg::*; #(
  parameter int SLOTS = 4,
  parameter int IMG_H = 8,
  parameter int GRPS  = 2,
  parameter int RW    = 3,
  parameter int GW    = 1,
  parameter int TW    = 2,
  parameter int AW    = 4,
  parameter int DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          p1,
  input  logic                          p2,
  input  logic [RW-1:0]                 row,
  input  logic [GW-1:0]                 grp,
  input  logic [TW-1:0]                 slot,
  output logic [TW-1:0]                 pslot,
  output logic [TW-1:0]                 nslot,
  output logic [SLOTS*LANES*NCOPY-1:0]  rd_en,
  output logic [SLOTS*LANES*NCOPY*AW-1:0] rd_addr
);
  logic [AW-1:0] a_mid, a_up, a_dn, a_lft, a_rgt;
  int r_i, r_up, r_dn, g_i, g_l, g_r;

  function automatic int kidx(input int t, input int b, input int c);
    return (t * LANES + b) * NCOPY + c;
  endfunction

  // clamped addresses; edge rows/groups read a harmless in-range word
  always_comb begin
    r_i  = int'(row);
    g_i  = int'(grp);
    r_up = (r_i == 0) ? 0 : r_i - 1;
    r_dn = (r_i == IMG_H - 1) ? r_i : r_i + 1;
    g_l  = (g_i == 0) ? 0 : g_i - 1;
    g_r  = (g_i == GRPS - 1) ? g_i : g_i + 1;
    a_mid = AW'(r_i  * GRPS + g_i);
    a_up  = AW'(r_up * GRPS + g_i);
    a_dn  = AW'(r_dn * GRPS + g_i);
    a_lft = AW'(r_i  * GRPS + g_l);
    a_rgt = AW'(r_i  * GRPS + g_r);
  end

  assign pslot = (slot == '0) ? TW'(SLOTS - 1) : slot - 1'b1;
  assign nslot = (int'(slot) == SLOTS - 1) ? '0 : slot + 1'b1;

  always_comb begin
    rd_en   = '0;
    rd_addr = '0;
    for (int t = 0; t < SLOTS; t++) begin
      for (int b = 0; b < LANES; b++) begin
        for (int c = 0; c < NCOPY; c++) begin
          if (p1) begin
            if (int'(slot) == t) begin
              rd_en[kidx(t, b, c)] = 1'b1;
              rd_addr[kidx(t, b, c)*AW +: AW] = (c == 0) ? a_mid : ((c == 1) ? a_up : a_dn);
            end else if (c == 0 && (int'(pslot) == t || int'(nslot) == t)) begin
              rd_en[kidx(t, b, c)] = 1'b1;
              rd_addr[kidx(t, b, c)*AW +: AW] = a_mid;
            end
          end else if (p2 && int'(slot) == t && c == 0) begin
            if (b == LANES - 1) begin
              rd_en[kidx(t, b, c)] = 1'b1;
              rd_addr[kidx(t, b, c)*AW +: AW] = a_lft;
            end else if (b == 0) begin
              rd_en[kidx(t, b, c)] = 1'b1;
              rd_addr[kidx(t, b, c)*AW +: AW] = a_rgt;
            end
          end
        end
      end
    end
  end

  // R1: every first-phase bank address stays inside the bank
  a_r1_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    p1 |-> (int'(a_mid) < DEPTH && int'(a_up) < DEPTH && int'(a_dn) < DEPTH));

  // R8: the two read phases of consecutive requests never overlap
  a_r8_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !(p1 && p2));
endmodule

// File: rtl/vf_nbr_assemble.sv
`timescale 1ns/1ps
module vf_nbr_assemble import vf_pkg::*; #(
  parameter int DW = 8
) (
  input  logic [LANES*DW-1:0]      h_ctr,
  input  logic [LANES*DW-1:0]      h_up,
  input  logic [LANES*DW-1:0]      h_dn,
  input  logic [LANES*DW-1:0]      h_prv,
  input  logic [LANES*DW-1:0]      h_nxt,
  input  logic [DW-1:0]            e_left,
  input  logic [DW-1:0]            e_right,
  input  logic                     at_l,
  input  logic                     at_r,
  input  logic                     at_t,
  input  logic                     at_b,
  input  logic                     at_f,
  input  logic                     at_e,
  output logic [LANES*NFLD*DW-1:0] bundle
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW-1:0] ctr, lft, rgt;
    assign ctr = h_ctr[l*DW +: DW];
    if (l == 0) begin : g_first
      assign lft = at_l ? ctr : e_left;
    end else begin : g_inner_l
      assign lft = h_ctr[(l-1)*DW +: DW];
    end
    if (l == LANES - 1) begin : g_last
      assign rgt = at_r ? ctr : e_right;
    end else begin : g_inner_r
      assign rgt = h_ctr[(l+1)*DW +: DW];
    end
    assign bundle[(l*NFLD + int'(F_CTR))*DW   +: DW] = ctr;
    assign bundle[(l*NFLD + int'(F_LEFT))*DW  +: DW] = lft;
    assign bundle[(l*NFLD + int'(F_RIGHT))*DW +: DW] = rgt;
    assign bundle[(l*NFLD + int'(F_UP))*DW    +: DW] = at_t ? ctr : h_up[l*DW +: DW];
    assign bundle[(l*NFLD + int'(F_DOWN))*DW  +: DW] = at_b ? ctr : h_dn[l*DW +: DW];
    assign bundle[(l*NFLD + int'(F_PREV))*DW  +: DW] = at_f ? ctr : h_prv[l*DW +: DW];
    assign bundle[(l*NFLD + int'(F_NEXT))*DW  +: DW] = at_e ? ctr : h_nxt[l*DW +: DW];
  end
endmodule

// File: rtl/vf_out_fifo.sv
`timescale 1ns/1ps
module vf_out_fifo #(
  parameter int BW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [BW-1:0] din,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [BW-1:0] out_data
);
  logic [BW-1:0] d0, d1;
  logic [1:0]    cnt;
  logic          pop;

  assign pop       = out_valid && out_ready;
  assign out_valid = (cnt != 2'd0);
  assign out_data  = d0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 2'd0;
      d0  <= '0;
      d1  <= '0;
    end else begin
      if (push && !pop) begin
        if (cnt == 2'd0) d0 <= din;
        else             d1 <= din;
        cnt <= cnt + 2'd1;
      end else if (pop && !push) begin
        d0  <= d1;
        cnt <= cnt - 2'd1;
      end else if (push && pop) begin
        if (cnt == 2'd1) d0 <= din;
        else begin
          d0 <= d1;
          d1 <= din;
        end
      end
    end
  end

  // R10: the credit gate upstream never lets a third result in
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt != 2'd2 || pop));

  // R10: a stalled result holds until taken
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/voxel_nbr_fetch.sv
`timescale 1ns/1ps
module voxel_nbr_fetch import vf_pkg::*; #(
  parameter int DW    = 8,
  parameter int IMG_W = 16,
  parameter int IMG_H = 8,
  parameter int IMG_D = 12,
  parameter int SLOTS = 4,
  localparam int GRPS = IMG_W / LANES,
  localparam int RW   = (IMG_H > 1) ? $clog2(IMG_H) : 1,
  localparam int GW   = (GRPS > 1) ? $clog2(GRPS) : 1,
  localparam int SW   = (IMG_D > 1) ? $clog2(IMG_D) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [RW-1:0]            wr_row,
  input  logic [GW-1:0]            wr_grp,
  input  logic [SW-1:0]            wr_slice,
  input  logic [LANES*DW-1:0]      wr_data,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [RW-1:0]            req_row,
  input  logic [GW-1:0]            req_grp,
  input  logic [SW-1:0]            req_slice,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES*NFLD*DW-1:0] out_data
);
  localparam int TW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int DEPTH = IMG_H * GRPS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NRAM  = SLOTS * LANES * NCOPY;
  localparam int BW    = LANES * NFLD * DW;

  function automatic int ridx(input int t, input int b, input int c);
    return (t * LANES + b) * NCOPY + c;
  endfunction

  // ---------------- request handshake and phase tracking
  logic          accept, pop, p1, p2, p3;
  logic [1:0]    credit;
  logic [RW-1:0] c_row;
  logic [GW-1:0] c_grp;
  logic [SW-1:0] c_slice;
  logic [TW-1:0] c_slot;

  assign pop       = out_valid && out_ready;
  assign req_ready = !p1 && (credit != 2'd2 || pop);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1     <= 1'b0;
      p2     <= 1'b0;
      p3     <= 1'b0;
      credit <= 2'd0;
    end else begin
      p1     <= accept;
      p2     <= p1;
      p3     <= p2;
      credit <= credit + {1'b0, accept} - {1'b0, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      c_row   <= req_row;
      c_grp   <= req_grp;
      c_slice <= req_slice;
      c_slot  <= TW'(int'(req_slice) % SLOTS);
    end
  end

  // ---------------- bank addressing
  logic [TW-1:0]      pslot, nslot;
  logic [NRAM-1:0]    rd_en;
  logic [NRAM*AW-1:0] rd_addr;
  logic [NRAM*DW-1:0] rdata;

  vf_addr_gen #(
    .SLOTS(SLOTS), .IMG_H(IMG_H), .GRPS(GRPS), .RW(RW), .GW(GW),
    .TW(TW), .AW(AW), .DEPTH(DEPTH)
  ) u_agen (
    .clk(clk), .rst_n(rst_n), .p1(p1), .p2(p2),
    .row(c_row), .grp(c_grp), .slot(c_slot),
    .pslot(pslot), .nslot(nslot), .rd_en(rd_en), .rd_addr(rd_addr)
  );

  // ---------------- bank storage: slot x column residue x row copy
  logic [TW-1:0] wr_slot;
  logic [AW-1:0] wr_addr;
  assign wr_slot = TW'(int'(wr_slice) % SLOTS);
  assign wr_addr = AW'(int'(wr_row) * GRPS + int'(wr_grp));

  for (genvar t = 0; t < SLOTS; t++) begin : g_slot
    for (genvar b = 0; b < LANES; b++) begin : g_bank
      for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        localparam int K = (t * LANES + b) * NCOPY + c;
        vf_bank_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
          .clk(clk),
          .we(wr_en && (wr_slot == TW'(t))),
          .waddr(wr_addr),
          .wdata(wr_data[b*DW +: DW]),
          .re(rd_en[K]),
          .raddr(rd_addr[K*AW +: AW]),
          .rdata(rdata[K*DW +: DW])
        );
      end
    end
  end

  // ---------------- phase 2: pick the first-phase words per lane
  logic [LANES*DW-1:0] s_ctr, s_up, s_dn, s_prv, s_nxt;
  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      s_ctr[b*DW +: DW] = rdata[ridx(int'(c_slot), b, 0)*DW +: DW];
      s_up [b*DW +: DW] = rdata[ridx(int'(c_slot), b, 1)*DW +: DW];
      s_dn [b*DW +: DW] = rdata[ridx(int'(c_slot), b, 2)*DW +: DW];
      s_prv[b*DW +: DW] = rdata[ridx(int'(pslot),  b, 0)*DW +: DW];
      s_nxt[b*DW +: DW] = rdata[ridx(int'(nslot),  b, 0)*DW +: DW];
    end
  end

  logic [LANES*DW-1:0] h_ctr, h_up, h_dn, h_prv, h_nxt;
  logic [TW-1:0]       s2_slot;
  logic                at_l, at_r, at_t, at_b, at_f, at_e;

  always_ff @(posedge clk) begin
    if (p2) begin
      h_ctr   <= s_ctr;
      h_up    <= s_up;
      h_dn    <= s_dn;
      h_prv   <= s_prv;
      h_nxt   <= s_nxt;
      s2_slot <= c_slot;
      at_l    <= (c_grp == '0);
      at_r    <= (int'(c_grp) == GRPS - 1);
      at_t    <= (c_row == '0);
      at_b    <= (int'(c_row) == IMG_H - 1);
      at_f    <= (c_slice == '0);
      at_e    <= (int'(c_slice) == IMG_D - 1);
    end
  end

  // ---------------- phase 3: edge columns arrive, bundle assembled
  logic [DW-1:0] e_left, e_right;
  logic [BW-1:0] bundle;
  assign e_left  = rdata[ridx(int'(s2_slot), LANES - 1, 0)*DW +: DW];
  assign e_right = rdata[ridx(int'(s2_slot), 0, 0)*DW +: DW];

  vf_nbr_assemble #(.DW(DW)) u_asm (
    .h_ctr(h_ctr), .h_up(h_up), .h_dn(h_dn), .h_prv(h_prv), .h_nxt(h_nxt),
    .e_left(e_left), .e_right(e_right),
    .at_l(at_l), .at_r(at_r), .at_t(at_t), .at_b(at_b), .at_f(at_f), .at_e(at_e),
    .bundle(bundle)
  );

  vf_out_fifo #(.BW(BW)) u_ofifo (
    .clk(clk), .rst_n(rst_n), .push(p3), .din(bundle),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  // R8: an accepted request blocks the next one for a cycle
  a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R10: outstanding results never exceed the two queue places
  a_r10_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= 2'd2);
endmodule

// File: tb/voxel_nbr_fetch_bench.sv
`timescale 1ns/1ps
module voxel_nbr_fetch_bench;
  localparam int DW = 8, IMG_W = 24, IMG_H = 5, IMG_D = 6, SLOTS = 4;
  localparam int LN = 8, NF = 7, GRPS = IMG_W / 8;
  localparam int RW = 3, GW = 2, SW = 3;
  localparam int BW = LN * NF * DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, req_valid = 1'b0, out_ready = 1'b0;
  logic [RW-1:0] wr_row = '0, req_row = '0;
  logic [GW-1:0] wr_grp = '0, req_grp = '0;
  logic [SW-1:0] wr_slice = '0, req_slice = '0;
  logic [LN*DW-1:0] wr_data = '0;
  logic req_ready, out_valid;
  logic [BW-1:0] out_data;

  always #2.5 clk = ~clk;

  voxel_nbr_fetch #(.DW(DW), .IMG_W(IMG_W), .IMG_H(IMG_H), .IMG_D(IMG_D), .SLOTS(SLOTS))
    u_voxel_nbr_fetch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_grp(wr_grp),
      .wr_slice(wr_slice), .wr_data(wr_data), .req_valid(req_valid), .req_ready(req_ready),
      .req_row(req_row), .req_grp(req_grp), .req_slice(req_slice),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  int checks = 0, fails = 0;
  int bp_mode = 0;
  logic [7:0] vox [SLOTS][IMG_H][IMG_W];
  logic [BW-1:0] exp_q [$];
  string tag_q [$];

  task automatic chk(input bit ok, input string what, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] expect_bundle(input int r, input int g, input int s);
    logic [BW-1:0] e;
    int sl, ps, ns, col;
    logic [7:0] c, v;
    sl = s % SLOTS; ps = (sl + SLOTS - 1) % SLOTS; ns = (sl + 1) % SLOTS;
    e = '0;
    for (int l = 0; l < LN; l++) begin
      col = g * 8 + l;
      c = vox[sl][r][col];
      e[(l*NF+0)*DW +: DW] = c;
      if (col == 0) v = c; else v = vox[sl][r][col-1];
      e[(l*NF+1)*DW +: DW] = v;
      if (col == IMG_W - 1) v = c; else v = vox[sl][r][col+1];
      e[(l*NF+2)*DW +: DW] = v;
      if (r == 0) v = c; else v = vox[sl][r-1][col];
      e[(l*NF+3)*DW +: DW] = v;
      if (r == IMG_H - 1) v = c; else v = vox[sl][r+1][col];
      e[(l*NF+4)*DW +: DW] = v;
      if (s == 0) v = c; else v = vox[ps][r][col];
      e[(l*NF+5)*DW +: DW] = v;
      if (s == IMG_D - 1) v = c; else v = vox[ns][r][col];
      e[(l*NF+6)*DW +: DW] = v;
    end
    return e;
  endfunction

  task automatic write_grp(input int s, input int r, input int g, input int seed);
    @(negedge clk);
    for (int i = 0; i < LN; i++) begin
      vox[s % SLOTS][r][g*8+i] = 8'(s*53 + r*29 + (g*8+i)*7 + seed*13 + 1);
      wr_data[i*DW +: DW] = vox[s % SLOTS][r][g*8+i];
    end
    wr_row = RW'(r); wr_grp = GW'(g); wr_slice = SW'(s); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill_slice(input int s, input int seed);
    for (int r = 0; r < IMG_H; r++)
      for (int g = 0; g < GRPS; g++) write_grp(s, r, g, seed);
  endtask

  // driver: present request, wait for acceptance, push the expectation
  task automatic send_req(input int r, input int g, input int s, input string tag);
    @(negedge clk);
    req_row = RW'(r); req_grp = GW'(g); req_slice = SW'(s); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back(expect_bundle(r, g, s));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8 ready after accept", BW'(req_ready), BW'(0));
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk)
    out_ready <= (bp_mode == 0) ? 1'b1 : ((bp_mode == 1) ? ($urandom_range(0, 2) != 0) : 1'b0);

  // monitor / scoreboard
  logic prev_stall = 1'b0;
  logic [BW-1:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R10 stalled bundle held", out_data, prev_data);
      if (exp_q.size() == 2 && !(out_valid && out_ready))
        chk(!req_ready, "R10 ready low with two outstanding", BW'(req_ready), BW'(0));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R9 unexpected result", out_data, '0);
        else begin
          chk(out_data === exp_q[0], {tag_q[0], " R2 R9 bundle"}, out_data, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog outstanding=%0d expected=0", exp_q.size());
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset ready", BW'(req_ready), BW'(1));
    chk(out_valid == 1'b0, "R11 reset valid", BW'(out_valid), BW'(0));

    for (int s = 0; s < SLOTS; s++) fill_slice(s, 0);

    // R9 latency on an interior request, R3 R4 R5 content
    bp_mode = 0;
    repeat (2) @(negedge clk);
    send_req(2, 1, 2, "R1 R3 R4 R5");
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 not early", BW'(out_valid), BW'(0));
    @(negedge clk);
    chk(out_valid == 1'b1, "R9 third edge", BW'(out_valid), BW'(1));
    drain();

    send_req(0, 0, 0, "R6 R7 corner low");
    send_req(IMG_H-1, GRPS-1, 1, "R6 R7 corner high");
    send_req(3, 0, 3, "R3 R5 R6 slot wrap");
    send_req(1, GRPS-1, 2, "R3 R6");
    drain();

    // slices beyond the window size reuse slots
    fill_slice(4, 1);
    fill_slice(5, 2);
    send_req(IMG_H-1, 1, 5, "R1 R5 R7 last slice");
    send_req(2, 2, 4, "R1 R5 wrapped slots");
    send_req(0, 1, 3, "R4 R5 R7");
    drain();

    // blocked consumer: both places fill, request side closes
    bp_mode = 2;
    @(negedge clk);
    send_req(1, 1, 4, "R10 hold A");
    send_req(2, 0, 5, "R10 hold B");
    repeat (6) @(negedge clk);
    chk(req_ready == 1'b0, "R10 blocked ready", BW'(req_ready), BW'(0));
    chk(out_valid == 1'b1, "R10 blocked valid", BW'(out_valid), BW'(1));
    bp_mode = 0;
    drain();

    // random burst with a random consumer
    bp_mode = 1;
    for (int n = 0; n < 40; n++)
      send_req($urandom_range(0, IMG_H-1), $urandom_range(0, GRPS-1),
               $urandom_range(0, IMG_D-1), "R3 R4 R5 R6 R7 R10 burst");
    drain();
    bp_mode = 0;
    chk(exp_q.size() == 0, "R9 all results delivered", BW'(exp_q.size()), BW'(0));
    finish_run();
  end
endmodule